// File: doc/BRIEF.md
# Stepped Duty Cycle Generator Selector

This block makes a fixed family of pulse-width waveforms that all share one period, picks one of them by a small index, and uses that choice to drive a single gate bit. A free-running counter sets the period. The upper nibble of the counter is compared against a set of thresholds, and each threshold gives one duty level. The levels rise in sixteenths, from five sixteenths to fifteen sixteenths, which makes eleven levels in all. An index from an external up/down tracker picks the active level. Index values above the top level are held at the top level.

The gate bit can come from two sources. The first is the selected digital level. The second is a bit from an external analog duty comparator. The digital source drives the gate when the alternator phase frequency is below the upper window limit, which is reported by a high-frequency flag. It also drives the gate whenever the system has not yet reached regulation, whatever the frequency. Otherwise the analog bit drives the gate. The source choice and the index are taken up only when the counter wraps, so a level never changes partway through a period. The gate bit is registered.

Top module: `stepped_duty_selector`

## Requirements
- R1: While reset (rst_n low) is asserted, gate is 0. Reset clears the counter, selects the digital source and sets the latched index to 0, so the first period after reset has a duty of 5/16 (80 high clocks out of 256).
- R2: The counter advances by one on every clock and wraps, so each PWM period is 256 clocks long. In digital mode each level goes high at the start of its period, so successive rising edges of gate are 256 clocks apart.
- R3: Level k (k = 0..10) is high while the counter's upper nibble is less than 5 + k. In digital mode with latched index k, gate is therefore high for the first (5 + k)·16 clocks of each 256-clock period and low for the rest of it.
- R4: A duty_idx value above 10 (11 to 15) selects level 10, which gives 240 high clocks per period.
- R5: When hi_freq is 0, the digital level drives gate.
- R6: When regulating is 0, the digital level drives gate, even if hi_freq is 1.
- R7: When hi_freq is 1 and regulating is 1, the analog source is chosen. In analog mode, gate equals the ana_cmp value from the previous clock.
- R8: duty_idx, hi_freq and regulating are sampled only at the clock edge where the counter goes from 255 to 0. A change during a period takes effect from the next period on.
- R9: gate is a registered output. Its value after an edge depends only on the counter, the latched choice and ana_cmp as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, PWM time base |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_idx | input | 4 | Requested duty level index (values above 10 are clamped to 10) |
| ana_cmp | input | 1 | Bit from the analog duty comparator |
| hi_freq | input | 1 | Phase frequency is above the upper window limit |
| regulating | input | 1 | System voltage has reached the regulation point |
| gate | output | 1 | Registered gate drive bit |

## Verification
The gate bit is due one clock after the edge that samples its inputs. An analog bit presented in one cycle therefore shows on gate after the next edge. An index or mode change shows up only from the first clock after the next wrap, which can be as much as 256 clocks later. The bench keeps a behavioural model that applies the same latencies. It drives inputs on the falling edge and compares gate against the model on every falling edge. It also counts high clocks over whole periods aligned to reset release and compares each count with (5 + k)·16, 256 or 0. The period tests change their inputs at the start of a period and expect the effect in the period after that.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic {
      SRC_ANALOG  = 1'b0,
      SRC_DIGITAL = 1'b1
   } dcs_src_e;

endpackage

// File: rtl/dcs_period_counter.sv
module dcs_period_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("dcs_period_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = (cnt_q == CNT_MAX);

   // R2: the counter steps by one on every clock
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/dcs_level_bank.sv
module dcs_level_bank #(
   parameter int NIB_W      = 4,
   parameter int NUM_LEVELS = 11,
   parameter int BASE_STEP  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NIB_W-1:0]      nib_i,
   output logic [NUM_LEVELS-1:0] lines_o
);

   localparam int STEPS = 1 << NIB_W;
   localparam int CMP_W = NIB_W + 1;

   if (BASE_STEP < 1 || BASE_STEP + NUM_LEVELS - 1 > STEPS) begin : g_bad_range
      $error("dcs_level_bank: levels must lie between 1 and 2**NIB_W steps");
   end

   for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
      localparam logic [CMP_W-1:0] THRESH = CMP_W'(BASE_STEP + k);
      assign lines_o[k] = ({1'b0, nib_i} < THRESH);
   end

   // R3: every level is high in the first slot of a period
   p_first_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_i == '0) |-> (&lines_o));

   // R3: the top nibble slot is low for every level that does not reach full scale
   if (BASE_STEP + NUM_LEVELS - 1 < STEPS) begin : g_top_chk
      p_last_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (&nib_i) |-> (lines_o == '0));
   end

endmodule

// File: rtl/dcs_source_latch.sv
module dcs_source_latch
   import dcs_pkg::*;
#(
   parameter int IDX_W        = 4,
   parameter int NUM_LEVELS   = 11,
   parameter bit ALIGN_SWITCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             hi_freq_i,
   input  logic             regulating_i,
   output dcs_src_e         src_o,
   output logic [$clog2(NUM_LEVELS)-1:0] sel_o
);

   localparam int SEL_W = $clog2(NUM_LEVELS);
   localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NUM_LEVELS - 1);

   if (IDX_W < SEL_W) begin : g_bad_idx
      $error("dcs_source_latch: IDX_W too narrow for NUM_LEVELS");
   end

   logic [SEL_W-1:0] sel_d;
   dcs_src_e         src_d;
   logic             take;

   always_comb begin
      if (int'(idx_i) > NUM_LEVELS - 1) sel_d = SEL_TOP;
      else                              sel_d = idx_i[SEL_W-1:0];
      src_d = (hi_freq_i && regulating_i) ? SRC_ANALOG : SRC_DIGITAL;
   end

   if (ALIGN_SWITCH) begin : g_aligned
      assign take = wrap_i;
   end else begin : g_free
      assign take = 1'b1;
   end

   dcs_src_e         src_q;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_DIGITAL;
         sel_q <= '0;
      end else if (take) begin
         src_q <= src_d;
         sel_q <= sel_d;
      end
   end

   assign src_o = src_q;
   assign sel_o = sel_q;

   // R4: the latched selection never passes the top level
   p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q <= SEL_TOP);

   // R8: the choice holds for the whole period when aligned switching is on
   if (ALIGN_SWITCH) begin : g_hold_chk
      p_hold_mid_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !wrap_i |=> ($stable(src_q) && $stable(sel_q)));
   end

endmodule

// File: rtl/stepped_duty_selector.sv
module stepped_duty_selector
   import dcs_pkg::*;
#(
   parameter int CNT_W        = 8,
   parameter int NIB_W        = 4,
   parameter int NUM_LEVELS   = 11,
   parameter int BASE_STEP    = 5,
   parameter int IDX_W        = 4,
   parameter bit ALIGN_SWITCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] duty_idx,
   input  logic             ana_cmp,
   input  logic             hi_freq,
   input  logic             regulating,
   output logic             gate
);

   localparam int SEL_W = $clog2(NUM_LEVELS);

   if (NIB_W > CNT_W) begin : g_bad_nib
      $error("stepped_duty_selector: NIB_W exceeds CNT_W");
   end

   logic [CNT_W-1:0]      cnt;
   logic                  wrap;
   logic [NUM_LEVELS-1:0] lines;
   dcs_src_e              src;
   logic [SEL_W-1:0]      sel;

   dcs_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_o  (cnt),
      .wrap_o (wrap)
   );

   dcs_level_bank #(
      .NIB_W      (NIB_W),
      .NUM_LEVELS (NUM_LEVELS),
      .BASE_STEP  (BASE_STEP)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .nib_i   (cnt[CNT_W-1 -: NIB_W]),
      .lines_o (lines)
   );

   dcs_source_latch #(
      .IDX_W        (IDX_W),
      .NUM_LEVELS   (NUM_LEVELS),
      .ALIGN_SWITCH (ALIGN_SWITCH)
   ) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .wrap_i       (wrap),
      .idx_i        (duty_idx),
      .hi_freq_i    (hi_freq),
      .regulating_i (regulating),
      .src_o        (src),
      .sel_o        (sel)
   );

   logic gate_d, gate_q;

   always_comb begin
      if (src == SRC_DIGITAL) gate_d = lines[sel];
      else                    gate_d = ana_cmp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate_d;
   end

   assign gate = gate_q;

   // R7: in analog mode the gate repeats the comparator bit one clock later
   p_gate_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_ANALOG) |=> (gate_q == $past(ana_cmp)));

   // R6: while not regulating, analog control is never chosen at a wrap
   p_start_digital_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !regulating) |=> (src == SRC_DIGITAL));

endmodule

// File: tb/stepped_duty_selector_test.sv
module stepped_duty_selector_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] duty_idx = 4'd0;
   logic       ana_cmp = 1'b0;
   logic       hi_freq = 1'b0;
   logic       regulating = 1'b1;
   logic       gate;

   int checks = 0;
   int errors = 0;
   int cycle  = 0;
   int rise_prev = -1;
   int rise_last = -1;

   // behavioural model state
   int  m_cnt  = 0;
   int  m_idx  = 0;
   bit  m_dig  = 1'b1;
   bit  m_gate = 1'b0;
   bit  cmp_on = 1'b0;

   always #10 clk = ~clk;

   stepped_duty_selector uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_idx   (duty_idx),
      .ana_cmp    (ana_cmp),
      .hi_freq    (hi_freq),
      .regulating (regulating),
      .gate       (gate)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
      end
   endtask

   // reference model, evaluated on the values present before each edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt  = 0;
         m_idx  = 0;
         m_dig  = 1'b1;
         m_gate = 1'b0;
      end else begin
         bit nxt;
         nxt = m_dig ? ((m_cnt / 16) < (5 + m_idx)) : ana_cmp;
         if (m_cnt == 255) begin
            m_dig = !hi_freq || !regulating;
            m_idx = (duty_idx > 10) ? 10 : int'(duty_idx);
         end
         m_cnt  = (m_cnt + 1) % 256;
         m_gate = nxt;
      end
   end

   // per-cycle comparison and rising edge log, away from the active edge
   bit gate_prev = 1'b0;
   always @(negedge clk) begin
      cycle++;
      if (cmp_on) check(gate == m_gate, "R9", gate, m_gate);
      if (rst_n && gate && !gate_prev) begin
         rise_prev = rise_last;
         rise_last = cycle;
      end
      gate_prev = gate;
   end

   task automatic period_highs(output int n);
      n = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         if (gate) n++;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int n;
      repeat (3) @(negedge clk);
      check(gate == 1'b0, "R1", gate, 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // period 0 uses the reset choice; request index 3 for period 1
      duty_idx = 4'd3;
      period_highs(n);
      check(n == 80, "R1", n, 80);
      duty_idx = 4'd15;
      period_highs(n);
      check(n == 128, "R3 R5", n, 128);
      duty_idx = 4'd10;
      period_highs(n);
      check(n == 240, "R4", n, 240);
      check(rise_last - rise_prev == 256, "R2", rise_last - rise_prev, 256);
      hi_freq = 1'b1; regulating = 1'b1; ana_cmp = 1'b1;
      period_highs(n);
      check(n == 240, "R8", n, 240);
      regulating = 1'b0;
      period_highs(n);
      check(n == 256, "R7", n, 256);
      regulating = 1'b1; ana_cmp = 1'b0; duty_idx = 4'd0;
      period_highs(n);
      check(n == 240, "R6", n, 240);
      period_highs(n);
      check(n == 0, "R7", n, 0);
      // analog tracking with a toggling comparator bit
      for (int i = 0; i < 20; i++) begin
         ana_cmp = i[0];
         @(negedge clk);
         check(gate == i[0], "R7", gate, i[0]);
      end
      // mixed traffic: inputs change freely, model compared every cycle
      for (int i = 0; i < 4000; i++) begin
         ana_cmp  = 1'($urandom_range(0, 1));
         if (i % 97 == 0) begin
            duty_idx   = 4'($urandom_range(0, 15));
            hi_freq    = 1'($urandom_range(0, 1));
            regulating = 1'($urandom_range(0, 1));
         end
         @(negedge clk);
      end
      // low frequency with a clamped index
      hi_freq = 1'b0; regulating = 1'b1; duty_idx = 4'd12;
      period_highs(n);
      duty_idx = 4'd0;
      @(negedge clk);
      while (gate) @(negedge clk);
      repeat (300) @(negedge clk);
      check(gate == m_gate, "R5", gate, m_gate);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule